// File: doc/BRIEF.md
# Triggered Three-Byte Message Sequencer

This block sits between an event source and a byte-wide serial transmitter. When a one-cycle trigger pulse arrives (typically the pulse a receiver raises after it has taken in one byte), the block hands a fixed three-byte message to the transmitter: 0x35 first, then 0xAA, then 0x77. For each byte it sets up an 8-bit data register and raises a start strobe for a single cycle.

The transmitter reports its state through a busy level and a one-cycle done pulse. The sequencer offers a byte only while busy is low. After every strobe it parks in a wait state until the done pulse for that byte arrives. A busy flag that the transmitter registers, and that therefore still reads low just after a strobe, cannot cause a second byte to be launched or a byte to be lost. Once the third byte is acknowledged the block goes back to idle and waits for the next trigger.

Top module: `msg_byte_seq`

## Requirements
- R1: While the active-low reset is asserted, and in the first cycle after it is released, the start strobe is low and the data register reads 0x00.
- R2: A trigger sampled in idle with busy low produces the first start strobe two clock edges later: the block arms on the first edge and fires on the second.
- R3: A start strobe is raised only in the cycle after one in which busy was sampled low. While busy stays high, no strobe appears.
- R4: The start strobe is never high for two consecutive cycles.
- R5: The data register changes only in a cycle in which the start strobe is high, so the byte is valid together with the strobe and held afterwards.
- R6: The bytes of one message are sent in the order 0x35, 0xAA, 0x77.
- R7: After a strobe, no further strobe is raised until the transmitter's done pulse has been sampled.
- R8: After the done pulse for the third byte the block is idle, and the next trigger starts again from 0x35.
- R9: A trigger that arrives while a message is in progress has no effect. Exactly three bytes are sent per accepted trigger.
- R10: Done pulses sampled while idle cause no strobe and do not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | One-cycle pulse that requests one message |
| tx_busy_i | input | 1 | Transmitter is shifting a byte |
| tx_done_i | input | 1 | One-cycle pulse when the transmitter finishes a byte |
| tx_data_o | output | DATA_W | Byte offered to the transmitter |
| tx_start_o | output | 1 | One-cycle strobe that launches tx_data_o |

## Verification
The sequencer is driven by a behavioural transmitter whose busy flag either rises promptly or lags the strobe by one cycle. The lagging case is what separates a design that waits for done from one that trusts busy alone. Other runs hold busy high across a trigger, to test that the strobe is gated, and fire extra triggers in the middle of a message, which must be dropped. Messages are also started back to back the moment the block is idle, and done pulses are injected while nothing is in flight. Every cycle the strobe and data are compared with a queue-based reference model, and the bytes the transmitter model captures are checked for order and for a count of three per accepted trigger.

// File: rtl/msgseq_pkg.sv
package msgseq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // waiting for a trigger
        SQ_ARM  = 2'd1,   // byte ready, waiting for transmitter free
        SQ_WAIT = 2'd2    // strobe issued, waiting for done pulse
    } sq_state_e;

endpackage

// File: rtl/msgseq_rom.sv
// Constant message store: byte k is taken from bits [k*DATA_W +: DATA_W].
module msgseq_rom #(
    parameter int DATA_W  = 8,
    parameter int MSG_LEN = 3,
    parameter int IDX_W   = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1,
    parameter logic [MSG_LEN*DATA_W-1:0] MSG = '0
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] entry [MSG_LEN];

    for (genvar k = 0; k < MSG_LEN; k++) begin : g_entry
        assign entry[k] = MSG[k*DATA_W +: DATA_W];
    end

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < MSG_LEN; k++) begin
            if (idx_i == IDX_W'(k)) byte_o = entry[k];
        end
    end
endmodule

// File: rtl/msgseq_idx.sv
// Position counter within the message.
module msgseq_idx #(
    parameter int MSG_LEN = 3,
    parameter int IDX_W   = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i) begin
            idx_d = '0;
        end else if (inc_i) begin
            idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) idx_q <= '0;
        else         idx_q <= idx_d;
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);

    // The position never walks past the last byte.
    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_q <= LAST_IDX);  // R6
endmodule

// File: rtl/msgseq_fsm.sv
module msgseq_fsm
    import msgseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rom_byte_i,
    input  logic              idx_last_i,
    output logic              idx_clr_o,
    output logic              idx_inc_o,
    output logic [DATA_W-1:0] data_o,
    output logic              start_o
);
    typedef struct packed {
        sq_state_e         st;
        logic              stb;
        logic [DATA_W-1:0] data;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.stb   = 1'b0;
        idx_clr_o = 1'b0;
        idx_inc_o = 1'b0;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (trig_i) begin
                    idx_clr_o = 1'b1;
                    r_d.st    = SQ_ARM;
                end
            end
            SQ_ARM: begin
                if (!busy_i) begin
                    r_d.stb  = 1'b1;
                    r_d.data = rom_byte_i;
                    r_d.st   = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (done_i) begin
                    if (idx_last_i) begin
                        r_d.st = SQ_IDLE;
                    end else begin
                        idx_inc_o = 1'b1;
                        r_d.st    = SQ_ARM;
                    end
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.st   <= SQ_IDLE;
            r_q.stb  <= 1'b0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data;
    assign start_o = r_q.stb;

    // Outstanding-byte tracker, used only by the checks below.
    logic pend_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      pend_q <= 1'b0;
        else if (start_o) pend_q <= 1'b1;
        else if (done_i)  pend_q <= 1'b0;
    end

    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);  // R4
    AST_STB_NEEDS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> !$past(busy_i));  // R3
    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_o |-> $stable(data_o));  // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> !$past(pend_q));  // R7
endmodule

// File: rtl/msg_byte_seq.sv
module msg_byte_seq #(
    parameter int DATA_W  = 8,
    parameter int MSG_LEN = 3,
    parameter logic [MSG_LEN*DATA_W-1:0] MSG = {8'h77, 8'hAA, 8'h35}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic              tx_busy_i,
    input  logic              tx_done_i,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              tx_start_o
);
    localparam int IDX_W = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;

    logic [IDX_W-1:0]  idx;
    logic              idx_last, idx_clr, idx_inc;
    logic [DATA_W-1:0] rom_byte;

    msgseq_idx #(.MSG_LEN(MSG_LEN), .IDX_W(IDX_W)) u_idx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (idx_clr),
        .inc_i  (idx_inc),
        .idx_o  (idx),
        .last_o (idx_last)
    );

    msgseq_rom #(.DATA_W(DATA_W), .MSG_LEN(MSG_LEN), .IDX_W(IDX_W), .MSG(MSG)) u_rom (
        .idx_i  (idx),
        .byte_o (rom_byte)
    );

    msgseq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .trig_i     (trig_i),
        .busy_i     (tx_busy_i),
        .done_i     (tx_done_i),
        .rom_byte_i (rom_byte),
        .idx_last_i (idx_last),
        .idx_clr_o  (idx_clr),
        .idx_inc_o  (idx_inc),
        .data_o     (tx_data_o),
        .start_o    (tx_start_o)
    );
endmodule

// File: tb/sim_msg_byte_seq.sv
module sim_msg_byte_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic       busy, done;
    logic [7:0] data;
    logic       start;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;  // 100 MHz

    // Transmitter model controls
    logic tx_busy = 1'b0, tx_busy_lag = 1'b0, tx_done = 1'b0;
    logic lag_mode = 1'b0, ext_busy = 1'b0, extra_done = 1'b0;
    int   tx_cnt = 0;
    int   tx_len = 4;
    logic [7:0] rx_log [$];

    assign busy = (lag_mode ? tx_busy_lag : tx_busy) | ext_busy;
    assign done = tx_done | extra_done;

    msg_byte_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
        .tx_busy_i(busy), .tx_done_i(done),
        .tx_data_o(data), .tx_start_o(start)
    );

    // Behavioural transmitter: registered busy, one-cycle done.
    always @(negedge clk) begin
        tx_busy_lag = tx_busy;
        if (!rst_n) begin
            tx_busy = 1'b0; tx_done = 1'b0; tx_cnt = 0;
        end else begin
            tx_done = 1'b0;
            if (tx_cnt > 0) begin
                tx_cnt = tx_cnt - 1;
                if (tx_cnt == 0) begin
                    tx_busy = 1'b0;
                    tx_done = 1'b1;
                end
            end else if (start) begin
                tx_busy = 1'b1;
                tx_cnt  = tx_len;
                rx_log.push_back(data);
            end
        end
    end

    // Reference model: queue of pending bytes, updated at each edge.
    logic [7:0] m_q [$];
    logic       m_arm = 1'b0, m_wait = 1'b0;
    logic       m_stb = 1'b0;
    logic [7:0] m_data = 8'h00;
    int         m_accepted = 0;

    always @(posedge clk) begin
        m_stb = 1'b0;
        if (!rst_n) begin
            m_q.delete(); m_arm = 1'b0; m_wait = 1'b0; m_data = 8'h00;
        end else if (m_wait) begin
            if (done) begin
                m_wait = 1'b0;
                m_arm  = (m_q.size() > 0);
            end
        end else if (m_arm) begin
            if (!busy) begin
                m_stb  = 1'b1;
                m_data = m_q.pop_front();
                m_arm  = 1'b0;
                m_wait = 1'b1;
            end
        end else if (trig) begin
            m_q = '{8'h35, 8'hAA, 8'h77};
            m_arm = 1'b1;
            m_accepted++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model (R2 R3 R4 R5 R7 R10).
    always @(negedge clk) begin
        if (rst_n) begin
            check(start == m_stb, "R2/R3/R7 strobe", start, m_stb);
            check(data == m_data, "R5/R10 data", data, m_data);
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_arm || m_wait) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(start == 1'b0, "R1 strobe in reset", start, 0);
        check(data == 8'h00, "R1 data in reset", data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start == 1'b0, "R1 strobe after reset", start, 0);
        check(data == 8'h00, "R1 data after reset", data, 0);

        // R2: strobe two edges after trigger
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        check(start == 1'b0, "R2 no strobe yet", start, 0);
        @(negedge clk);
        check(start == 1'b1, "R2 strobe timing", start, 1);
        check(data == 8'h35, "R2 first byte", data, 8'h35);
        wait_idle();
        repeat (3) @(negedge clk);
        check(rx_log.size() == 3, "R6 count msg1", rx_log.size(), 3);

        // R3: busy held high blocks the strobe
        ext_busy = 1'b1;
        pulse_trig();
        repeat (10) @(negedge clk);
        check(rx_log.size() == 3, "R3 blocked while busy", rx_log.size(), 3);
        ext_busy = 1'b0;
        wait_idle();

        // R9: triggers in the middle of a message are dropped
        pulse_trig();
        repeat (4) @(negedge clk);
        pulse_trig();
        repeat (7) @(negedge clk);
        pulse_trig();
        wait_idle();
        repeat (5) @(negedge clk);
        check(rx_log.size() == 9, "R9 extra triggers ignored", rx_log.size(), 9);

        // R7 R8: lagging busy, back-to-back messages
        lag_mode = 1'b1;
        for (int m = 0; m < 3; m++) begin
            pulse_trig();
            wait_idle();
        end
        lag_mode = 1'b0;
        tx_len = 1;
        for (int m = 0; m < 2; m++) begin
            pulse_trig();
            wait_idle();
        end
        repeat (4) @(negedge clk);

        // R10: done pulses in idle do nothing
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); extra_done = 1'b1;
            @(negedge clk); extra_done = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(start == 1'b0, "R10 no strobe from idle done", start, 0);
        check(data == 8'h77, "R10 data held", data, 8'h77);

        // R6 R8: order and totals over all messages
        check(rx_log.size() == 3 * m_accepted, "R9 three per trigger",
              rx_log.size(), 3 * m_accepted);
        for (int i = 0; i < rx_log.size(); i++) begin
            logic [7:0] exp_b;
            exp_b = (i % 3 == 0) ? 8'h35 : ((i % 3 == 1) ? 8'hAA : 8'h77);
            check(rx_log[i] == exp_b, "R6/R8 byte order", rx_log[i], exp_b);
        end
        summary();
    end
endmodule